// File: doc/BRIEF.md
# Region-Based Memory Access Filter

This block sits beside a memory port and judges every transaction that arrives there against a small table of programmable address windows. Each window other than window 0 has an inclusive page range with 4 KB granularity and one enable bit for each filter port. Each window also carries a two-bit code that says which directions a secure transaction may use, and a mask that says which non-secure masters may read or write. Window 0 is a fixed background that covers the whole address space on every filter, so an address that no other window claims still receives a decision.

The transaction side presents an address, a direction, a security state, a master ID and the filter port the transaction came through. One cycle later the block answers with permit or deny and an overlap flag. The table is programmed through a plain 32-bit word-addressed register port. The read path is combinational. Build parameters and a fixed identification value can be read from the same port.

Top module: `region_filter`

## Requirements
- R1: After reset, windows 1 and up read back with zero attributes and zero masks, window 0 has code 0 and mask 0, `respValid` is low, and every transaction is denied.
- R2: `respValid` is high exactly one cycle after `reqValid` was high. While `respValid` is low, `respPermit` and `respOverlap` are both low.
- R3: A window n of 1 or more matches when base page <= address[ADDR_W-1:12] <= top page, so both ends are inclusive. A base-low readback shows bits [11:0] as zero, and a top-low readback shows bits [11:0] as 0xFFF.
- R4: When two or more windows of index 1 or more match, the transaction is denied and `respOverlap` is high.
- R5: When no window of index 1 or more matches, the code and mask of window 0 decide the transaction.
- R6: A secure transaction (`txNonSecure`=0) uses the secure code in bits [31:30] of the attribute word. Code 0 allows nothing, 1 allows reads, 2 allows writes and 3 allows both.
- R7: A non-secure transaction is permitted on a read when bit `txId` of the mask word is set, and on a write when bit 16+`txId` is set. The secure code plays no part in this decision.
- R8: In window 0, writes to base and top are ignored. Its base reads as 0, its top reads as all ones up to ADDR_W-1, and its enable bits read as all ones whatever is written. Its code and its mask are writable.
- R9: Window n occupies words 0x40+8n to 0x45+8n: base low, base high, top low, top high, attribute, mask. Base low and top low carry address bits [31:12]. The high words carry the address bits from 32 upward, and bits at or above ADDR_W read as 0.
- R10: Word 0 reads {NUM_FILTERS-1 in [25:24], ADDR_W-1 in [13:8], NUM_REGIONS-1 in [4:0]}. With the defaults this is 0x03002708.
- R11: Words 0x3FC to 0x3FF read the bytes 0x0D, 0xF0, 0x05 and 0xB1 in bits [7:0], which gives the identification value 0xB105F00D with the least significant byte first.
- R12: A window of index 1 or more takes part in a decision only when bit `txFilter` of the enable field (attribute bits [NUM_FILTERS-1:0]) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 10 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| reqValid | input | 1 | Transaction present |
| txAddr | input | ADDR_W | Transaction byte address |
| txWrite | input | 1 | 1 for write, 0 for read |
| txNonSecure | input | 1 | 1 for a non-secure transaction |
| txId | input | ID_W | Master ID |
| txFilter | input | FW | Filter port the transaction came through |
| respValid | output | 1 | Decision present |
| respPermit | output | 1 | Transaction allowed |
| respOverlap | output | 1 | More than one window matched |

## Verification
The hardest case to reach is an overlap, which needs two windows that are both enabled on the transaction's filter and both contain its page. The edges of those windows are where an off-by-one in the inclusive compare would show. To reach both, the random phase keeps every window inside a range of about 80 pages and draws transaction pages from the same range, so overlaps and exact edge pages come up often. Directed cases build one known overlap, separate it again through the filter enables, and test each end of a window one page inside and one page outside.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  typedef enum logic [2:0] {
    FLD_BASE_LO = 3'd0,
    FLD_BASE_HI = 3'd1,
    FLD_TOP_LO  = 3'd2,
    FLD_TOP_HI  = 3'd3,
    FLD_ATTR    = 3'd4,
    FLD_IDMASK  = 3'd5,
    FLD_NONE    = 3'd7
  } field_e;

  typedef struct packed {
    logic       wr;
    field_e     field;
    logic [3:0] region;
  } regStrobe_t;

  localparam logic [31:0] COMPONENT_ID = 32'hB105F00D;
  localparam int CODE_LSB    = 30;
  localparam int WR_MASK_LSB = 16;
  localparam int LO_PAGE_BITS = 20;
endpackage

// File: rtl/rmf_ctrl.sv
module rmf_ctrl
  import rmf_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 40
) (
  input  logic        regWrEn,
  input  logic [9:0]  regAddr,
  output regStrobe_t  strobe,
  output logic [31:0] constData
);
  localparam logic [31:0] BUILD_WORD = (32'(NUM_FILTERS - 1) << 24) |
                                       (32'(ADDR_W - 1) << 8) |
                                       32'(NUM_REGIONS - 1);

  logic [6:0] slot;
  logic       inRange;
  field_e     fld;

  always_comb begin
    slot    = regAddr[9:3] - 7'd8;
    inRange = (regAddr[9:3] >= 7'd8) && (slot < 7'(NUM_REGIONS));
    fld     = (regAddr[2:0] <= 3'd5) ? field_e'(regAddr[2:0]) : FLD_NONE;

    strobe.region = slot[3:0];
    strobe.field  = inRange ? fld : FLD_NONE;
    strobe.wr     = regWrEn && inRange && (fld != FLD_NONE);

    if (regAddr == 10'd0)
      constData = BUILD_WORD;
    else if (regAddr[9:2] == 8'hFF)
      constData = {24'd0, 8'(COMPONENT_ID >> {regAddr[1:0], 3'b000})};
    else
      constData = '0;
  end
endmodule

// File: rtl/rmf_regs.sv
module rmf_regs
  import rmf_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output logic [ADDR_W-13:0]     basePg [NUM_REGIONS-1],
  output logic [ADDR_W-13:0]     topPg  [NUM_REGIONS-1],
  output logic [NUM_FILTERS-1:0] enBits [NUM_REGIONS-1],
  output logic [1:0]             code   [NUM_REGIONS],
  output logic [31:0]            idMask [NUM_REGIONS]
);
  localparam int PW = ADDR_W - 12;

  logic [31:0] rdWord [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic [PW-1:0]          bReg, tReg;
    logic [NUM_FILTERS-1:0] eReg;
    logic [1:0]             cReg;
    logic [31:0]            mReg;
    logic                   hit;

    assign hit = strobe.wr && (strobe.region == 4'(g));

    if (g == 0) begin : gFixed
      assign bReg = '0;
      assign tReg = '1;
      assign eReg = '1;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cReg <= '0;
          mReg <= '0;
        end else if (hit) begin
          if (strobe.field == FLD_ATTR)   cReg <= wrData[CODE_LSB +: 2];
          if (strobe.field == FLD_IDMASK) mReg <= wrData;
        end
      end
    end else begin : gProg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bReg <= '0;
          tReg <= '0;
          eReg <= '0;
          cReg <= '0;
          mReg <= '0;
        end else if (hit) begin
          case (strobe.field)
            FLD_BASE_LO: for (int b = 0; b < LO_PAGE_BITS; b++) bReg[b] <= wrData[b+12];
            FLD_BASE_HI: for (int b = LO_PAGE_BITS; b < PW; b++) bReg[b] <= wrData[b-LO_PAGE_BITS];
            FLD_TOP_LO:  for (int b = 0; b < LO_PAGE_BITS; b++) tReg[b] <= wrData[b+12];
            FLD_TOP_HI:  for (int b = LO_PAGE_BITS; b < PW; b++) tReg[b] <= wrData[b-LO_PAGE_BITS];
            FLD_ATTR: begin
              eReg <= wrData[NUM_FILTERS-1:0];
              cReg <= wrData[CODE_LSB +: 2];
            end
            FLD_IDMASK:  mReg <= wrData;
            default: ;
          endcase
        end
      end
      assign basePg[g-1] = bReg;
      assign topPg[g-1]  = tReg;
      assign enBits[g-1] = eReg;
    end

    assign code[g]   = cReg;
    assign idMask[g] = mReg;

    always_comb begin
      rdWord[g] = '0;
      case (strobe.field)
        FLD_BASE_LO: for (int b = 0; b < LO_PAGE_BITS; b++) rdWord[g][b+12] = bReg[b];
        FLD_BASE_HI: for (int b = LO_PAGE_BITS; b < PW; b++) rdWord[g][b-LO_PAGE_BITS] = bReg[b];
        FLD_TOP_LO: begin
          rdWord[g][11:0] = 12'hFFF;
          for (int b = 0; b < LO_PAGE_BITS; b++) rdWord[g][b+12] = tReg[b];
        end
        FLD_TOP_HI:  for (int b = LO_PAGE_BITS; b < PW; b++) rdWord[g][b-LO_PAGE_BITS] = tReg[b];
        FLD_ATTR: begin
          rdWord[g][CODE_LSB +: 2]     = cReg;
          rdWord[g][NUM_FILTERS-1:0] = eReg;
        end
        FLD_IDMASK:  rdWord[g] = mReg;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (strobe.field != FLD_NONE && strobe.region == 4'(i)) rdData = rdWord[i];
  end
endmodule

// File: rtl/rmf_judge.sv
module rmf_judge
  import rmf_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 40,
  parameter int ID_W        = 4,
  localparam int FW = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ADDR_W-1:0]      txAddr,
  input  logic                   txWrite,
  input  logic                   txNonSecure,
  input  logic [ID_W-1:0]        txId,
  input  logic [FW-1:0]          txFilter,
  input  logic [ADDR_W-13:0]     basePg [NUM_REGIONS-1],
  input  logic [ADDR_W-13:0]     topPg  [NUM_REGIONS-1],
  input  logic [NUM_FILTERS-1:0] enBits [NUM_REGIONS-1],
  input  logic [1:0]             code   [NUM_REGIONS],
  input  logic [31:0]            idMask [NUM_REGIONS],
  output logic                   respValid,
  output logic                   respPermit,
  output logic                   respOverlap
);
  logic [NUM_REGIONS-2:0] regionHit;
  logic [1:0]  selCode;
  logic [31:0] selMask;
  logic        overlap, allowSec, allowNs, allow;

  for (genvar k = 0; k < NUM_REGIONS - 1; k++) begin : gCmp
    assign regionHit[k] = enBits[k][txFilter] &&
                          ({basePg[k], 12'h000} <= txAddr) &&
                          (txAddr <= {topPg[k], 12'hFFF});
  end

  always_comb begin
    selCode = code[0];
    selMask = idMask[0];
    for (int r = 1; r < NUM_REGIONS; r++) begin
      if (regionHit[r-1]) begin
        selCode = code[r];
        selMask = idMask[r];
      end
    end
    overlap  = $countones(regionHit) > 1;
    allowSec = txWrite ? selCode[1] : selCode[0];
    allowNs  = txWrite ? selMask[WR_MASK_LSB + int'(txId)] : selMask[int'(txId)];
    allow    = txNonSecure ? allowNs : allowSec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respPermit  <= 1'b0;
      respOverlap <= 1'b0;
    end else begin
      respValid   <= reqValid;
      respPermit  <= reqValid && !overlap && allow;
      respOverlap <= reqValid && overlap;
    end
  end
endmodule

// File: rtl/region_filter.sv
module region_filter
  import rmf_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 40,
  parameter int ID_W        = 4,
  localparam int FW = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [9:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic              txWrite,
  input  logic              txNonSecure,
  input  logic [ID_W-1:0]   txId,
  input  logic [FW-1:0]     txFilter,
  output logic              respValid,
  output logic              respPermit,
  output logic              respOverlap
);
  regStrobe_t             strobe;
  logic [31:0]            constData, fieldData;
  logic [ADDR_W-13:0]     basePg [NUM_REGIONS-1];
  logic [ADDR_W-13:0]     topPg  [NUM_REGIONS-1];
  logic [NUM_FILTERS-1:0] enBits [NUM_REGIONS-1];
  logic [1:0]             code   [NUM_REGIONS];
  logic [31:0]            idMask [NUM_REGIONS];

  rmf_ctrl #(.NUM_REGIONS(NUM_REGIONS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W)) uCtrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobe(strobe), .constData(constData)
  );

  rmf_regs #(.NUM_REGIONS(NUM_REGIONS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData), .rdData(fieldData),
    .basePg(basePg), .topPg(topPg), .enBits(enBits), .code(code), .idMask(idMask)
  );

  rmf_judge #(.NUM_REGIONS(NUM_REGIONS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W),
              .ID_W(ID_W)) uJudge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txAddr(txAddr), .txWrite(txWrite),
    .txNonSecure(txNonSecure), .txId(txId), .txFilter(txFilter),
    .basePg(basePg), .topPg(topPg), .enBits(enBits), .code(code), .idMask(idMask),
    .respValid(respValid), .respPermit(respPermit), .respOverlap(respOverlap)
  );

  assign regRdData = fieldData | constData;
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker #(
  parameter int NUM_FILTERS = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic [9:0]  regAddr,
  input logic [31:0] regRdData,
  input logic        reqValid,
  input logic        respValid,
  input logic        respPermit,
  input logic        respOverlap
);
  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respPermit && !respOverlap)); // R2
  AST_OVERLAP_DENIES: assert property (@(posedge clk) disable iff (!rstN)
    respOverlap |-> !respPermit); // R4
  AST_BG_BASE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 10'h040) |-> (regRdData == 32'd0)); // R8
  AST_BG_ALL_FILTERS: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 10'h044) |-> (regRdData[NUM_FILTERS-1:0] == '1)); // R8
  AST_ID_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 10'h3FC) |-> (regRdData == 32'h0000000D)); // R11
endmodule

bind region_filter rmf_checker #(.NUM_FILTERS(NUM_FILTERS)) uChk (.*);

// File: tb/sim_region_filter.sv
module sim_region_filter;
  localparam int NR = 9;
  localparam int NF = 4;
  localparam int AW = 40;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [9:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          reqValid = 1'b0;
  logic [AW-1:0] txAddr = '0;
  logic          txWrite = 1'b0;
  logic          txNonSecure = 1'b0;
  logic [IW-1:0] txId = '0;
  logic [1:0]    txFilter = '0;
  logic          respValid, respPermit, respOverlap;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  longint unsigned mBase [NR];
  longint unsigned mTop  [NR];
  logic [3:0]      mEn   [NR];
  logic [1:0]      mCode [NR];
  logic [31:0]     mMask [NR];

  region_filter #(.NUM_REGIONS(NR), .NUM_FILTERS(NF), .ADDR_W(AW), .ID_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .reqValid(reqValid), .txAddr(txAddr), .txWrite(txWrite),
    .txNonSecure(txNonSecure), .txId(txId), .txFilter(txFilter),
    .respValid(respValid), .respPermit(respPermit), .respOverlap(respOverlap)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [9:0] wAddr(input int n, input int f);
    return 10'(32'h40 + 8 * n + f);
  endfunction

  task automatic setRegion(input int n, input longint unsigned bp, input longint unsigned tp,
                           input logic [3:0] en, input logic [1:0] cd, input logic [31:0] mk);
    if (n != 0) begin
      regWrite(wAddr(n, 0), 32'(bp << 12));
      regWrite(wAddr(n, 1), 32'(bp >> 20));
      regWrite(wAddr(n, 2), 32'(tp << 12));
      regWrite(wAddr(n, 3), 32'(tp >> 20));
      mBase[n] = bp; mTop[n] = tp; mEn[n] = en;
    end
    regWrite(wAddr(n, 4), {cd, 26'd0, en});
    regWrite(wAddr(n, 5), mk);
    mCode[n] = cd; mMask[n] = mk;
  endtask

  task automatic expectResp(input longint unsigned a, input bit wr, input bit ns,
                            input int id, input int f,
                            output bit permit, output bit ovl, output int cnt);
    longint unsigned pg;
    int sel;
    bit allow;
    pg = a >> 12; cnt = 0; sel = 0;
    for (int n = 1; n < NR; n++)
      if (mEn[n][f] && pg >= mBase[n] && pg <= mTop[n]) begin cnt++; sel = n; end
    if (ns) allow = wr ? mMask[sel][16 + id] : mMask[sel][id];
    else    allow = wr ? mCode[sel][1] : mCode[sel][0];
    ovl = (cnt > 1);
    permit = !ovl && allow;
  endtask

  task automatic doTx(input string tag, input longint unsigned a, input bit wr, input bit ns,
                      input int id, input int f);
    bit ePermit, eOvl;
    int cnt;
    string t;
    expectResp(a, wr, ns, id, f, ePermit, eOvl, cnt);
    if (tag.len() != 0) t = tag;
    else if (cnt > 1) t = "R4";
    else if (cnt == 0) t = "R5";
    else t = ns ? "R7" : "R6";
    @(negedge clk);
    reqValid = 1'b1; txAddr = AW'(a); txWrite = wr; txNonSecure = ns;
    txId = IW'(id); txFilter = 2'(f);
    @(negedge clk);
    reqValid = 1'b0;
    check({t, " valid"}, 64'(respValid), 64'd1);
    check({t, " permit"}, 64'(respPermit), 64'(ePermit));
    check({t, " overlap"}, 64'(respOverlap), 64'(eOvl));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd777));
    for (int n = 0; n < NR; n++) begin
      mBase[n] = 0; mTop[n] = 0; mEn[n] = '0; mCode[n] = '0; mMask[n] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1 respValid after reset", 64'(respValid), 64'd0);
    regRead(wAddr(3, 4), d);  check("R1 window 3 attr", 64'(d), 64'd0);
    regRead(wAddr(0, 5), d);  check("R1 window 0 mask", 64'(d), 64'd0);
    doTx("R1", 64'h0, 1'b0, 1'b0, 0, 0);
    doTx("R1", 64'h12345000, 1'b1, 1'b1, 3, 2);

    // R10, R11: constant words
    regRead(10'h000, d); check("R10 build word", 64'(d), 64'h03002708);
    regRead(10'h3FC, d); check("R11 id byte 0", 64'(d), 64'h0D);
    regRead(10'h3FD, d); check("R11 id byte 1", 64'(d), 64'hF0);
    regRead(10'h3FE, d); check("R11 id byte 2", 64'(d), 64'h05);
    regRead(10'h3FF, d); check("R11 id byte 3", 64'(d), 64'hB1);

    // R8: background window
    regWrite(wAddr(0, 0), 32'h12345000);
    regRead(wAddr(0, 0), d); check("R8 window 0 base lo", 64'(d), 64'd0);
    regWrite(wAddr(0, 3), 32'h0);
    regRead(wAddr(0, 2), d); check("R8 window 0 top lo", 64'(d), 64'hFFFFFFFF);
    regRead(wAddr(0, 3), d); check("R8 window 0 top hi", 64'(d), 64'hFF);
    setRegion(0, 0, 0, 4'h0, 2'd3, 32'h0);
    regRead(wAddr(0, 4), d); check("R8 window 0 attr", 64'(d), 64'hC000000F);

    // R9: field layout and width masking
    regWrite(wAddr(2, 0), 32'h12345678);
    regRead(wAddr(2, 0), d); check("R9 base lo", 64'(d), 64'h12345000);
    regWrite(wAddr(2, 1), 32'hFFFFFFFF);
    regRead(wAddr(2, 1), d); check("R9 base hi masked", 64'(d), 64'hFF);
    regWrite(wAddr(2, 2), 32'h00002000);
    regRead(wAddr(2, 2), d); check("R3 top lo reads FFF", 64'(d), 64'h00002FFF);
    setRegion(2, 0, 0, 4'h0, 2'd0, 32'h0);

    // R3, R6, R12: window 1 pages 0x10..0x1F, filter 0 only, read only
    setRegion(1, 64'h10, 64'h1F, 4'b0001, 2'd1, 32'h0);
    doTx("R3 low edge", 64'h10000, 1'b0, 1'b0, 0, 0);
    doTx("R3 high edge", 64'h1FFFF, 1'b0, 1'b0, 0, 0);
    doTx("R3 below edge", 64'h0FFFF, 1'b1, 1'b0, 0, 0);
    doTx("R3 above edge", 64'h20000, 1'b1, 1'b0, 0, 0);
    doTx("R6 read only blocks write", 64'h15000, 1'b1, 1'b0, 0, 0);
    doTx("R12 other filter uses window 0", 64'h15000, 1'b1, 1'b0, 0, 1);

    // R4: window 2 overlaps window 1 on filter 0
    setRegion(2, 64'h18, 64'h28, 4'b0011, 2'd3, 32'hFFFFFFFF);
    doTx("R4 overlap", 64'h19000, 1'b0, 1'b0, 0, 0);
    doTx("R12 overlap split by filter", 64'h19000, 1'b0, 1'b0, 0, 1);

    // R7: non-secure mask
    setRegion(3, 64'h40, 64'h4F, 4'b1111, 2'd0, (32'h1 << 5) | (32'h1 << 18));
    doTx("R7 ns read allowed", 64'h41000, 1'b0, 1'b1, 5, 3);
    doTx("R7 ns read denied", 64'h41000, 1'b0, 1'b1, 2, 3);
    doTx("R7 ns write allowed", 64'h41000, 1'b1, 1'b1, 2, 3);
    doTx("R7 ns write denied", 64'h41000, 1'b1, 1'b1, 5, 3);
    doTx("R6 code 0 denies secure", 64'h41000, 1'b0, 1'b0, 5, 3);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      if (it % 30 == 0) begin
        int n;
        longint unsigned bp;
        n = int'($urandom_range(0, NR - 1));
        bp = longint'($urandom_range(0, 63));
        setRegion(n, bp, bp + longint'($urandom_range(0, 15)), 4'($urandom),
                  2'($urandom), $urandom);
      end
      begin
        longint unsigned a;
        if ($urandom_range(0, 9) == 0)
          a = {longint'($urandom_range(0, 32'h0FFFFFFF)), 12'h000} | longint'($urandom_range(0, 4095));
        else
          a = (longint'($urandom_range(0, 79)) << 12) | longint'($urandom_range(0, 4095));
        doTx("", a, 1'($urandom), 1'($urandom), int'($urandom_range(0, 15)),
             int'($urandom_range(0, 3)));
      end
    end

    @(negedge clk);
    check("R2 idle after last request", 64'(respValid), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule